// File: doc/BRIEF.md
# Phase-Shifted Edge-Placed PWM Channel

This block drives one PWM output whose timing comes from a counter shared with other channels. It owns no counter and no period register. Each cycle it receives the shared count, a strobe marking the start of a timebase period, and the period length. The output becomes active at a programmable leading count (the phase shift) and inactive at a trailing count (phase shift plus duty). Software can therefore place the pulse anywhere inside the shared period, rather than always starting it at count zero.

Software writes duty, phase and polarity through a plain one-cycle write port into shadow registers. The shadow values are copied into the working set only on the timebase strobe, so a period in progress never changes shape. The port has no handshake: a write is accepted in the cycle `wr_en` is high. The block has no streaming data path, so it has no valid/ready interface.

Top module: `pwm_edge_chan`

## Requirements
- R1: While reset is held, and after reset is released, the output is low. The working and shadow settings reset to duty 0, phase 0 and active-high.
- R2: The pulse pattern repeats with the period of the external timebase. A period starts in the cycle in which `tb_wrap` is high, which is the cycle in which `tb_count` is 0.
- R3: For a count `c` sampled at a rising edge, the channel is active after that edge exactly when duty is not 0 and phase <= c < phase + duty. `pwm_out` shows this from the edge on, which is one cycle of latency.
- R4: Writes change only the shadow registers. The working set loads from the shadow registers at the edge where `tb_wrap` is high, so a write made in the middle of a period has no effect until the next period.
- R5: Register select 2 holds the polarity in bit 0: 0 means active-high and 1 means active-low, in which case `pwm_out` is inverted. Register select 0 holds the duty and register select 1 holds the phase, both in ticks. Polarity is double-buffered like the other settings.
- R6: Counts are 16 bits wide, and the timebase period may be any value from 2 to 65535. The count always stays below the period.
- R7: When phase + duty is at least the period, the output stays active up to the period boundary. It does not carry over into the next period.
- R8: A duty of 0 keeps the output inactive for the whole period, whatever the phase.
- R9: A write in the same cycle as `tb_wrap` is not taken into the period that starts there. It takes effect at the following boundary.
- R10: A write with register select 3 changes no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_count | input | 16 | Shared timebase count |
| tb_wrap | input | 1 | High in the first cycle (count 0) of each timebase period |
| tb_period | input | 16 | Timebase period in ticks (2 to 65535) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 duty, 1 phase, 2 polarity, 3 unused |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | PWM output after polarity |

## Verification
`pwm_out` responds to each sampled count one rising edge later. A new setting appears starting with the count-0 sample of the first period whose opening strobe comes after the write edge. The bench runs its own model of the timebase counter and waits for the falling edge that precedes a count-0 edge. It then compares `pwm_out` with the expected level for count k at the falling edge after the k-th rising edge, one full period at a time. Writes that must not take effect yet are driven inside a checked period, either at count 0 (the collision case) or in the middle of the period. The period that follows is checked as well, to confirm that the write arrived later.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;
  localparam int TB_W = 16;

  typedef enum logic [1:0] {
    SEL_DUTY  = 2'd0,
    SEL_PHASE = 2'd1,
    SEL_POL   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pwm_edge_cfg.sv
module pwm_edge_cfg #(
  parameter int W = pwm_edge_pkg::TB_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         tb_wrap,
  output logic [W-1:0] eff_duty,
  output logic [W-1:0] eff_phase,
  output logic         eff_low,
  output logic         act_low
);
  import pwm_edge_pkg::*;

  logic [W-1:0] shd_duty, shd_phase, act_duty, act_phase;
  logic         shd_low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shd_duty  <= '0;
      shd_phase <= '0;
      shd_low   <= 1'b0;
      act_duty  <= '0;
      act_phase <= '0;
      act_low   <= 1'b0;
    end else begin
      if (wr_en) begin
        case (reg_sel_e'(wr_sel))
          SEL_DUTY:  shd_duty  <= wr_data;
          SEL_PHASE: shd_phase <= wr_data;
          SEL_POL:   shd_low   <= wr_data[0];
          default:   ;
        endcase
      end
      if (tb_wrap) begin
        act_duty  <= shd_duty;
        act_phase <= shd_phase;
        act_low   <= shd_low;
      end
    end
  end

  // The period that opens at this edge already uses the shadow values.
  assign eff_duty  = tb_wrap ? shd_duty  : act_duty;
  assign eff_phase = tb_wrap ? shd_phase : act_phase;
  assign eff_low   = tb_wrap ? shd_low   : act_low;

  // R4
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tb_wrap |=> ($stable(act_duty) && $stable(act_phase) && $stable(act_low)));

  // R9
  wr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_wrap && wr_en) |=> (act_duty == $past(shd_duty) && act_phase == $past(shd_phase)
                            && act_low == $past(shd_low)));
endmodule

// File: rtl/pwm_edge_cmp.sv
module pwm_edge_cmp #(
  parameter int W = pwm_edge_pkg::TB_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tb_count,
  input  logic [W-1:0] tb_period,
  input  logic         tb_wrap,
  input  logic [W-1:0] duty,
  input  logic [W-1:0] phase,
  output logic         on_q
);
  logic [W:0] trail, lim;
  logic       on_nxt;

  assign trail  = {1'b0, phase} + {1'b0, duty};
  // Clamp the trailing edge at the period so the pulse never spills over.
  assign lim    = (trail > {1'b0, tb_period}) ? {1'b0, tb_period} : trail;
  assign on_nxt = (duty != '0) && (tb_count >= phase) && ({1'b0, tb_count} < lim);

  always_ff @(posedge clk) begin
    if (!rst_n) on_q <= 1'b0;
    else        on_q <= on_nxt;
  end

  // R7
  no_spill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_wrap && phase != '0) |=> !on_q);

  // R8
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0) |=> !on_q);
endmodule

// File: rtl/pwm_edge_chan.sv
module pwm_edge_chan #(
  parameter int W = pwm_edge_pkg::TB_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tb_count,
  input  logic         tb_wrap,
  input  logic [W-1:0] tb_period,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic         pwm_out
);
  logic [W-1:0] eff_duty, eff_phase;
  logic         eff_low, act_low, on_q;

  pwm_edge_cfg #(.W(W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .tb_wrap   (tb_wrap),
    .eff_duty  (eff_duty),
    .eff_phase (eff_phase),
    .eff_low   (eff_low),
    .act_low   (act_low)
  );

  pwm_edge_cmp #(.W(W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .tb_count  (tb_count),
    .tb_period (tb_period),
    .tb_wrap   (tb_wrap),
    .duty      (eff_duty),
    .phase     (eff_phase),
    .on_q      (on_q)
  );

  assign pwm_out = on_q ^ act_low;

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_count < tb_period) && (tb_period >= 2));

  // R2
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tb_wrap |-> (tb_count == '0));

  // R5
  pol_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_wrap && eff_duty == '0) |=> (pwm_out == $past(eff_low)));
endmodule

// File: tb/sim_pwm_edge_chan.sv
module sim_pwm_edge_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = '0;
  logic [15:0] per = 16'd20;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_out;
  logic        tb_wrap;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (cnt >= per - 16'd1) cnt <= '0;
    else                    cnt <= cnt + 16'd1;
  end
  assign tb_wrap = (cnt == 16'd0);

  pwm_edge_chan u0 (
    .clk(clk), .rst_n(rst_n), .tb_count(cnt), .tb_wrap(tb_wrap),
    .tb_period(per), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pwm_out(pwm_out)
  );

  function automatic logic exp_lvl(int k, int ph, int du, bit low, int p);
    bit act;
    act = (du != 0) && (k >= ph) && (k < ph + du) && (k < p);
    return act ^ low;
  endfunction

  task automatic wr(input logic [1:0] sel, input int data);
    if (cnt == 16'd0) @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = 16'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sync;
    do @(negedge clk); while (cnt != 16'd0);
  endtask

  // Must be entered at a falling edge with cnt == 0.
  task automatic chk_period(input string tag, input int ph, input int du, input bit low,
                            input int wr_at, input logic [1:0] sel, input int data);
    int bad_k = -1;
    logic got = 1'b0;
    logic exp = 1'b0;
    for (int k = 0; k < int'(per); k++) begin
      if (k == wr_at) begin
        wr_en = 1'b1; wr_sel = sel; wr_data = 16'(data);
      end
      @(negedge clk);
      wr_en = 1'b0;
      if (pwm_out !== exp_lvl(k, ph, du, low, int'(per)) && bad_k < 0) begin
        bad_k = k; got = pwm_out; exp = exp_lvl(k, ph, du, low, int'(per));
      end
    end
    checks++;
    if (bad_k >= 0) begin
      errors++;
      $display("FAIL %s count=%0d actual=%b expected=%b", tag, bad_k, got, exp);
    end
  endtask

  task automatic t_reset;
    checks++;
    if (pwm_out !== 1'b0) begin
      errors++; $display("FAIL R1 in reset actual=%b expected=0", pwm_out);
    end
    @(negedge clk); rst_n = 1'b1;
    sync;
    chk_period("R1", 0, 0, 0, -1, 2'd0, 0);
  endtask

  task automatic t_left;
    wr(2'd0, 5);
    sync;
    chk_period("R3 left", 0, 5, 0, -1, 2'd0, 0);
    chk_period("R2 repeat", 0, 5, 0, -1, 2'd0, 0);
  endtask

  task automatic t_phase;
    wr(2'd1, 7); wr(2'd0, 4);
    sync;
    chk_period("R3 phase", 7, 4, 0, -1, 2'd0, 0);
  endtask

  task automatic t_mid;
    sync;
    chk_period("R4 old kept", 7, 4, 0, 9, 2'd0, 9);
    chk_period("R4 new applied", 7, 9, 0, -1, 2'd0, 0);
  endtask

  task automatic t_spill;
    wr(2'd1, 15); wr(2'd0, 10);
    sync;
    chk_period("R7 spill", 15, 10, 0, -1, 2'd0, 0);
    chk_period("R7 no carry", 15, 10, 0, -1, 2'd0, 0);
    wr(2'd1, 0); wr(2'd0, 20);
    sync;
    chk_period("R7 full", 0, 20, 0, -1, 2'd0, 0);
  endtask

  task automatic t_zero;
    wr(2'd1, 3); wr(2'd0, 0);
    sync;
    chk_period("R8 zero", 3, 0, 0, -1, 2'd0, 0);
  endtask

  task automatic t_pol;
    wr(2'd1, 2); wr(2'd0, 6); wr(2'd2, 1);
    sync;
    chk_period("R5 active-low", 2, 6, 1, -1, 2'd0, 0);
  endtask

  task automatic t_collide;
    sync;
    chk_period("R9 held", 2, 6, 1, 0, 2'd0, 11);
    chk_period("R9 later", 2, 11, 1, -1, 2'd0, 0);
  endtask

  task automatic t_ignored;
    chk_period("R10 same", 2, 11, 1, 3, 2'd3, 1);
    chk_period("R10 next", 2, 11, 1, -1, 2'd0, 0);
  endtask

  task automatic t_period;
    sync;
    per = 16'd7;
    chk_period("R6 short", 2, 11, 1, -1, 2'd0, 0);
    wr(2'd1, 0); wr(2'd0, 1); wr(2'd2, 0);
    sync;
    per = 16'd2;
    chk_period("R6 min", 0, 1, 0, -1, 2'd0, 0);
    chk_period("R6 min again", 0, 1, 0, -1, 2'd0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_left;
    t_phase;
    t_mid;
    t_spill;
    t_zero;
    t_pol;
    t_collide;
    t_ignored;
    t_period;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule